// File: doc/BRIEF.md
# Circular Product-Term Sharing Router

This block is a configurable routing stage placed between a bank of wide OR terms and the macrocells that consume them. Every output picks any subset of seven neighbouring input terms: the term with its own index and the three on each side. It drives the OR of the terms it picked. Neighbour indices wrap at the ends of the bank, so the first and last outputs can reach terms at the far end.

The routing for each output is held in an 8-bit row. Seven bits are window enables and one bit is a bypass. Rows are written one at a time through a small synchronous port, addressed by output index, and can be read back at any time. The path from terms to outputs has no registers, so a function can be built as wide as seven grouped terms in a single pass. A new row reaches the datapath only at a clock edge, which means a reconfiguration never shows a half-written routing.

Top module: `term_share_array`

## Requirements
- R1: While reset is held low, every row reads back as zero and every output is 0, whatever the input terms are.
- R2: Bit k (0..6) of an output's row enables input term (n + k - 3) mod 32 for output n, and the output is the OR of all enabled terms. Bit 3 is therefore the output's own term.
- R3: Window indices wrap modulo 32. Output 0 reaches terms 29, 30, 31, 0, 1, 2 and 3, and output 31 reaches terms 28 to 31 and 0 to 2.
- R4: An output whose seven enable bits are all clear, with bypass clear, drives 0 for any input terms.
- R5: When bit 7 (bypass) of row n is set, output n equals input term n, and the seven enable bits of that row have no effect.
- R6: A row write presented with the write enable high takes effect at the next rising clock edge. Before that edge the output still follows the old row. No other row changes.
- R7: The read port returns, combinationally, the 8-bit row stored at the read address.
- R8: The path from terms to outputs is combinational, so outputs follow a change of the input terms with no clock edge.
- R9: With all seven enables of a row set, the output is 1 when any single term in its window is 1 and 0 when only terms outside the window are 1. This joins seven grouped terms (35 product terms at five per term) in one pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Active-low asynchronous reset; clears all rows |
| terms_in | input | 32 | Input OR terms, one per index |
| cfg_we | input | 1 | Row write enable |
| cfg_addr | input | 5 | Output index of the row being written |
| cfg_wdata | input | 8 | Row data: bits 6..0 window enables, bit 7 bypass |
| cfg_rd_addr | input | 5 | Output index of the row being read |
| cfg_rdata | output | 8 | Stored row at cfg_rd_addr |
| sum_out | output | 32 | Routed outputs, one per macrocell |

## Verification
A single term at a single enable bit checks the sign and offset of each window position. Terms placed at 29 and 2 against rows 0 and 31 show whether the modulo wrap is applied, as opposed to clamping or dropping indices at the ends. An all-ones term vector against an empty row separates "no enables" from a stuck output. A term inside a fully enabled window against one just outside it confirms that the window is exactly seven wide. Random rows checked against random terms, together with a test that holds a write across the edge, cover the general OR and the point at which a write takes effect.

// File: rtl/term_share_array.sv
module term_share_array #(
  parameter int N_TERMS = 32,
  parameter int HALF    = 3,
  localparam int WIN    = 2 * HALF + 1,
  localparam int RW     = WIN + 1,
  localparam int AW     = $clog2(N_TERMS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TERMS-1:0] terms_in,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [RW-1:0]      cfg_wdata,
  input  logic [AW-1:0]      cfg_rd_addr,
  output logic [RW-1:0]      cfg_rdata,
  output logic [N_TERMS-1:0] sum_out
);

  logic [RW-1:0] row_q [N_TERMS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_TERMS; i++) row_q[i] <= '0;
    end else if (cfg_we) begin
      row_q[cfg_addr] <= cfg_wdata;
    end
  end

  assign cfg_rdata = row_q[cfg_rd_addr];

  for (genvar n = 0; n < N_TERMS; n++) begin : g_out
    logic [WIN-1:0] win;
    for (genvar k = 0; k < WIN; k++) begin : g_tap
      localparam int IDX = (n + k - HALF + N_TERMS) % N_TERMS;
      assign win[k] = terms_in[IDX];
    end
    assign sum_out[n] = row_q[n][WIN] ? terms_in[n] : |(win & row_q[n][WIN-1:0]);
  end

endmodule

module term_share_array_chk #(
  parameter int N_TERMS = 32,
  parameter int HALF    = 3,
  localparam int WIN    = 2 * HALF + 1,
  localparam int RW     = WIN + 1,
  localparam int AW     = $clog2(N_TERMS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_TERMS-1:0] terms_in,
  input logic               cfg_we,
  input logic [AW-1:0]      cfg_addr,
  input logic [RW-1:0]      cfg_wdata,
  input logic [AW-1:0]      cfg_rd_addr,
  input logic [RW-1:0]      cfg_rdata,
  input logic [N_TERMS-1:0] sum_out
);

  // R4
  zero_terms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    terms_in == '0 |-> sum_out == '0);

  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && cfg_rd_addr == $past(cfg_addr)) |-> cfg_rdata == $past(cfg_wdata));

  // R7
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && $stable(cfg_rd_addr)) |-> $stable(cfg_rdata));

  // R5
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[WIN] |-> sum_out[cfg_rd_addr] == terms_in[cfg_rd_addr]);

  // R4
  empty_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata == '0 |-> !sum_out[cfg_rd_addr]);

  // R3
  wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_addr == '0 && cfg_rdata == RW'(1)) |-> sum_out[0] == terms_in[N_TERMS-HALF]);

endmodule

bind term_share_array term_share_array_chk #(.N_TERMS(N_TERMS), .HALF(HALF)) i_chk (
  .clk(clk), .rst_n(rst_n), .terms_in(terms_in), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rd_addr(cfg_rd_addr),
  .cfg_rdata(cfg_rdata), .sum_out(sum_out)
);

// File: tb/test_term_share_array.sv
`timescale 1ns/1ps
module test_term_share_array;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] terms_in = '0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [4:0]  cfg_rd_addr = '0;
  logic [7:0]  cfg_rdata;
  logic [31:0] sum_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] mrow [32];

  always #5 clk = ~clk;

  term_share_array i_term_share_array (
    .clk(clk), .rst_n(rst_n), .terms_in(terms_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rdata(cfg_rdata), .sum_out(sum_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] t);
    logic [31:0] o = '0;
    for (int n = 0; n < 32; n++) begin
      if (mrow[n][7]) o[n] = t[n];
      else for (int k = 0; k < 7; k++)
        if (mrow[n][k] && t[(n + k - 3 + 32) % 32]) o[n] = 1'b1;
    end
    return o;
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    mrow[a] = d;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 32; i++) wr(i, 8'h00);
  endtask

  task automatic t_reset();
    terms_in = '1;
    repeat (2) @(negedge clk);
    chk("R1 outputs", sum_out, 32'h0);
    cfg_rd_addr = 5'd5; #1;
    chk("R1 readback", 32'(cfg_rdata), 32'h0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 32; i++) mrow[i] = 8'h00;
  endtask

  task automatic t_offsets();
    clear_all();
    for (int k = 0; k < 7; k++) begin
      wr(10, 8'(1 << k));
      terms_in = 32'(1) << (10 + k - 3); #1;
      chk("R2 single tap", sum_out, 32'(1) << 10);
      terms_in = 32'(1) << (10 + ((k + 1) % 7) - 3); #1;
      chk("R2 other tap", sum_out, 32'h0);
    end
    wr(10, 8'h00);
  endtask

  task automatic t_wrap();
    wr(0, 8'h01);
    terms_in = 32'(1) << 29; #1;
    chk("R3 row0 tap0", sum_out, 32'h1);
    wr(0, 8'h00);
    wr(31, 8'h40);
    terms_in = 32'h4; #1;
    chk("R3 row31 tap6", sum_out, 32'h8000_0000);
    terms_in = 32'h1; #1;
    chk("R3 row31 term0 disabled", sum_out, 32'h0);
    wr(31, 8'h00);
  endtask

  task automatic t_empty();
    wr(12, 8'h7f);
    terms_in = '1; #1;
    chk("R4 empty rows", sum_out, 32'h0000_1000);
    wr(12, 8'h00); #1;
    chk("R4 all clear", sum_out, 32'h0);
  endtask

  task automatic t_bypass();
    wr(7, 8'h80);
    terms_in = 32'h80; #1;
    chk("R5 bypass passes", sum_out, 32'h80);
    wr(7, 8'hff);
    terms_in = 32'h10; #1;
    chk("R5 enables ignored", sum_out, 32'h0);
    terms_in = 32'h90; #1;
    chk("R5 bypass high", sum_out, 32'h80);
    wr(7, 8'h00);
  endtask

  task automatic t_timing();
    wr(3, 8'h08);
    terms_in = 32'h8;
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5'd3; cfg_wdata = 8'h00; #1;
    chk("R6 before edge", sum_out, 32'h8);
    @(negedge clk);
    cfg_we = 0; mrow[3] = 8'h00;
    chk("R6 after edge", sum_out, 32'h0);
    cfg_rd_addr = 5'd4; #1;
    chk("R6 neighbour row", 32'(cfg_rdata), 32'h0);
  endtask

  task automatic t_readback();
    wr(17, 8'hA5); wr(18, 8'h3C);
    cfg_rd_addr = 5'd17; #1;
    chk("R7 row17", 32'(cfg_rdata), 32'hA5);
    cfg_rd_addr = 5'd18; #1;
    chk("R7 row18", 32'(cfg_rdata), 32'h3C);
    wr(17, 8'h00); wr(18, 8'h00);
  endtask

  task automatic t_comb();
    wr(25, 8'h08);
    @(negedge clk);
    #2 terms_in = 32'(1) << 25;
    #1 chk("R8 rise no clock", sum_out, 32'(1) << 25);
    terms_in = '0;
    #1 chk("R8 fall no clock", sum_out, 32'h0);
    wr(25, 8'h00);
  endtask

  task automatic t_wide();
    wr(20, 8'h7f);
    for (int t = 17; t <= 23; t++) begin
      terms_in = 32'(1) << t; #1;
      chk("R9 window term", sum_out, 32'(1) << 20);
    end
    terms_in = (32'(1) << 16) | (32'(1) << 24); #1;
    chk("R9 outside window", sum_out, 32'h0);
    wr(20, 8'h00);
  endtask

  task automatic t_random();
    for (int i = 0; i < 32; i++) wr(i, 8'($urandom));
    for (int p = 0; p < 20; p++) begin
      terms_in = $urandom; #1;
      chk("R2 random", sum_out, model(terms_in));
    end
    for (int i = 0; i < 32; i++) begin
      cfg_rd_addr = 5'(i); #1;
      chk("R7 random readback", 32'(cfg_rdata), 32'(mrow[i]));
    end
  endtask

  initial begin
    t_reset();
    t_offsets();
    t_wrap();
    t_empty();
    t_bypass();
    t_timing();
    t_readback();
    t_comb();
    t_wide();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog R1..all actual timeout expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule